// File: doc/BRIEF.md
# Receive Descriptor Ring Controller

This block moves received frames into host buffers through a circular ring of descriptors kept in a small internal table. Each descriptor has a status word, a byte count and a buffer base address. Software prepares a descriptor by writing its buffer address and setting its empty (owned-by-hardware) bit. The controller fills the buffer from a byte stream, writes the final status and byte count back, and clears the empty bit to return the descriptor. It then follows the wrap bit or steps to the next entry.

When the controller reaches a descriptor that software has not returned, it stops and discards incoming frames. It counts each discarded frame and keeps the pointer where it is. A kick strobe makes it look at the current descriptor again. A restart input, like reset, sends the pointer home and leaves the controller inactive. Every completed frame sets a frame-received bit in a write-one-to-clear event register. Buffer memory writes appear as a per-byte strobe, address and data.

The engine is a five-state machine:
- IDLE: inactive. Incoming frames are dropped. A kick goes to READY if the current descriptor is owned.
- READY: owned and waiting. A first beat goes to RECV, or straight to CLOSE if it is also the end beat.
- RECV: inside a frame. The end beat goes to CLOSE.
- CLOSE: writes the descriptor back and advances the pointer. It goes to READY if the next descriptor is owned, otherwise to IDLE.
- DROP: discards the rest of a refused frame. The end beat goes to IDLE.

Restart forces IDLE from any state.

Top module: `rx_desc_ring`

## Requirements
- R1: A buffer byte is written only while the current descriptor's status bit 15 (empty) is set. On completion the controller clears bit 15. It never changes a descriptor it does not own.
- R2: After completion the pointer goes to index 0 if the completed descriptor has status bit 13 (wrap) set; otherwise it goes to the next index.
- R3: A completed descriptor gets status bit 11 (last) set. Its length field (host select 1) holds the number of bytes received, frame check sequence included.
- R4: Status bit 5 (length error) is set when the byte count exceeds 1520 or is below 64. Only the first 1520 bytes of a frame are written to the buffer.
- R5: Flags sampled with the end beat are ORed into the status: CRC error to bit 2, non-octet alignment to bit 4, FIFO overrun to bit 1, late collision to bit 0. Flags already present are kept.
- R6: Each accepted byte produces one buffer write at the buffer base address plus the byte's offset in the frame, carrying that byte.
- R7: When the next descriptor is not owned the controller goes inactive. A frame arriving while inactive is dropped without any buffer write, the drop counter increments once, and the pointer stays.
- R8: A kick re-examines the current descriptor: it resumes if the empty bit is set and stays inactive if not. A kick while active has no effect.
- R9: Each completion sets bit 25 of the event register (host select 3). A host write to select 3 with bit 25 set clears it. `frame_evt` shows its value.
- R10: Reset and restart set the pointer to 0 and leave the controller inactive. Reset also zeroes all descriptors and the drop counter.
- R11: The host port selects a field with `host_sel`: 0 status, 1 length, 2 buffer address, 3 event register. Reads are combinational and writes take effect at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| restart | input | 1 | Return pointer home, go inactive |
| kick | input | 1 | Re-examine current descriptor |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 2 | Field select |
| host_idx | input | IDX_W | Descriptor index for host access |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data |
| rx_valid | input | 1 | Byte beat valid |
| rx_data | input | 8 | Byte of frame |
| rx_end | input | 1 | Final beat of frame |
| rx_crc_bad | input | 1 | CRC error flag, with end beat |
| rx_align_bad | input | 1 | Non-octet alignment flag, with end beat |
| rx_fifo_ovr | input | 1 | FIFO overrun flag, with end beat |
| rx_late_col | input | 1 | Late collision flag, with end beat |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_addr | output | 32 | Buffer byte address |
| buf_byte | output | 8 | Buffer byte data |
| frame_evt | output | 1 | Frame-received event bit |
| drop_count | output | DROP_W | Dropped frame count |
| cur_index | output | IDX_W | Current descriptor pointer |
| rx_active | output | 1 | Controller is active (READY, RECV or CLOSE) |

## Verification
The assertions assume that software does not clear the empty bit of a descriptor the controller owns, and does not rewrite it mid-frame. They also assume that at least one idle cycle separates a frame's end beat from the next frame's first beat, so no beat lands in CLOSE. The directed stimulus writes only descriptors the controller is not using. It drops `rx_valid` for several cycles after each frame, never pulses kick and a beat together, and keeps frame lengths below the counter limit.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    localparam int B_EMPTY  = 15;
    localparam int B_WRAP   = 13;
    localparam int B_LAST   = 11;
    localparam int B_LERR   = 5;
    localparam int B_ALIGN  = 4;
    localparam int B_CRC    = 2;
    localparam int B_OVR    = 1;
    localparam int B_COL    = 0;
    localparam int EVT_BIT  = 25;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_READY = 3'd1,
        S_RECV  = 3'd2,
        S_CLOSE = 3'd3,
        S_DROP  = 3'd4
    } rx_state_t;
endpackage

// File: rtl/rxr_desc_ram.sv
module rxr_desc_ram #(
    parameter int NUM_DESC = 8,
    parameter int LEN_W    = 16,
    localparam int IDX_W   = $clog2(NUM_DESC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_we,
    input  logic [1:0]       host_sel,
    input  logic [IDX_W-1:0] host_idx,
    input  logic [31:0]      host_wdata,
    input  logic             eng_we,
    input  logic [IDX_W-1:0] eng_idx,
    input  logic [15:0]      eng_status,
    input  logic [LEN_W-1:0] eng_len,
    input  logic [IDX_W-1:0] a_idx,
    input  logic [IDX_W-1:0] b_idx,
    output logic [15:0]      a_status,
    output logic [31:0]      a_addr,
    output logic             b_empty,
    output logic [15:0]      h_status,
    output logic [LEN_W-1:0] h_len,
    output logic [31:0]      h_addr
);
    logic [15:0]      st_mem  [NUM_DESC];
    logic [LEN_W-1:0] len_mem [NUM_DESC];
    logic [31:0]      adr_mem [NUM_DESC];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_DESC; k++) begin
                st_mem[k]  <= '0;
                len_mem[k] <= '0;
                adr_mem[k] <= '0;
            end
        end else begin
            if (host_we) begin
                unique case (host_sel)
                    2'd0:    st_mem[host_idx]  <= host_wdata[15:0];
                    2'd1:    len_mem[host_idx] <= host_wdata[LEN_W-1:0];
                    2'd2:    adr_mem[host_idx] <= host_wdata;
                    default: ;
                endcase
            end
            if (eng_we) begin
                st_mem[eng_idx]  <= eng_status;
                len_mem[eng_idx] <= eng_len;
            end
        end
    end

    assign a_status = st_mem[a_idx];
    assign a_addr   = adr_mem[a_idx];
    assign b_empty  = st_mem[b_idx][rxr_pkg::B_EMPTY];
    assign h_status = st_mem[host_idx];
    assign h_len    = len_mem[host_idx];
    assign h_addr   = adr_mem[host_idx];
endmodule

// File: rtl/rxr_len_track.sv
module rxr_len_track #(
    parameter int LEN_W   = 16,
    parameter int MAX_LEN = 1520,
    parameter int MIN_LEN = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [LEN_W-1:0] cnt,
    output logic             room,
    output logic             len_bad
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt <= '0;
        else if (inc && cnt != '1)
            cnt <= cnt + LEN_W'(1);
    end

    assign room    = cnt < LEN_W'(MAX_LEN);
    assign len_bad = (cnt > LEN_W'(MAX_LEN)) || (cnt < LEN_W'(MIN_LEN));
endmodule

// File: rtl/rxr_engine.sv
module rxr_engine
    import rxr_pkg::*;
#(
    parameter int NUM_DESC = 8,
    parameter int LEN_W    = 16,
    parameter int DROP_W   = 16,
    localparam int IDX_W   = $clog2(NUM_DESC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              kick,
    input  logic              rx_valid,
    input  logic              rx_end,
    input  logic [3:0]        rx_flags,
    input  logic [15:0]       cur_status,
    input  logic [31:0]       cur_addr,
    input  logic              nxt_empty,
    input  logic [LEN_W-1:0]  byte_cnt,
    input  logic              room,
    input  logic              len_bad,
    input  logic              evt_clr,
    output logic              cnt_clr,
    output logic              cnt_inc,
    output logic              wb_we,
    output logic [15:0]       wb_status,
    output logic              buf_we,
    output logic [31:0]       buf_addr,
    output logic [IDX_W-1:0]  ptr,
    output logic [IDX_W-1:0]  nxt_ptr,
    output logic              evt_q,
    output logic [DROP_W-1:0] drop_cnt,
    output logic              active
);
    rx_state_t  st, st_n;
    logic [3:0] err_q;
    logic       accept;
    logic [15:0] s;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= S_IDLE;
            ptr      <= '0;
            err_q    <= '0;
            evt_q    <= 1'b0;
            drop_cnt <= '0;
        end else begin
            st <= restart ? S_IDLE : st_n;
            if (restart)
                ptr <= '0;
            else if (st == S_CLOSE)
                ptr <= nxt_ptr;
            if (accept && rx_end)
                err_q <= rx_flags;
            if (st == S_IDLE && rx_valid && !restart)
                drop_cnt <= drop_cnt + DROP_W'(1);
            evt_q <= (evt_q && !evt_clr) || (st == S_CLOSE);
        end
    end

    always_comb begin
        st_n      = st;
        accept    = rx_valid && (st == S_READY || st == S_RECV);
        nxt_ptr   = cur_status[B_WRAP] ? '0 : ptr + IDX_W'(1);
        s         = cur_status;
        s[B_EMPTY] = 1'b0;
        s[B_LAST]  = 1'b1;
        s[B_LERR]  = s[B_LERR]  | len_bad;
        s[B_CRC]   = s[B_CRC]   | err_q[3];
        s[B_ALIGN] = s[B_ALIGN] | err_q[2];
        s[B_OVR]   = s[B_OVR]   | err_q[1];
        s[B_COL]   = s[B_COL]   | err_q[0];
        wb_status = s;
        wb_we     = (st == S_CLOSE) && !restart;
        cnt_inc   = accept;
        cnt_clr   = restart || st == S_CLOSE || st == S_IDLE || st == S_DROP;
        buf_we    = accept && room;
        buf_addr  = cur_addr + {{(32-LEN_W){1'b0}}, byte_cnt};
        active    = (st == S_READY) || (st == S_RECV) || (st == S_CLOSE);
        unique case (st)
            S_IDLE: begin
                if (rx_valid)
                    st_n = rx_end ? S_IDLE : S_DROP;
                else if (kick && cur_status[B_EMPTY])
                    st_n = S_READY;
            end
            S_READY: if (rx_valid) st_n = rx_end ? S_CLOSE : S_RECV;
            S_RECV:  if (rx_valid && rx_end) st_n = S_CLOSE;
            S_CLOSE: st_n = nxt_empty ? S_READY : S_IDLE;
            S_DROP:  if (rx_valid && rx_end) st_n = S_IDLE;
            default: st_n = S_IDLE;
        endcase
    end

    AST_OWNED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> cur_status[B_EMPTY]);                                   // R1
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && !restart && !(kick && cur_status[B_EMPTY]))
        |=> (st == S_IDLE || st == S_DROP));                               // R8
    AST_DROP_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == S_IDLE || st == S_DROP) && !restart) |=> (ptr == $past(ptr))); // R7
    AST_EVT_ON_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_CLOSE) |=> evt_q);                                        // R9
    AST_RESTART_HOME: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (ptr == '0 && st == S_IDLE));                          // R10
endmodule

// File: rtl/rx_desc_ring.sv
module rx_desc_ring #(
    parameter int NUM_DESC = 8,
    parameter int LEN_W    = 16,
    parameter int MAX_LEN  = 1520,
    parameter int MIN_LEN  = 64,
    parameter int DROP_W   = 16,
    localparam int IDX_W   = $clog2(NUM_DESC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              kick,
    input  logic              host_we,
    input  logic [1:0]        host_sel,
    input  logic [IDX_W-1:0]  host_idx,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_end,
    input  logic              rx_crc_bad,
    input  logic              rx_align_bad,
    input  logic              rx_fifo_ovr,
    input  logic              rx_late_col,
    output logic              buf_we,
    output logic [31:0]       buf_addr,
    output logic [7:0]        buf_byte,
    output logic              frame_evt,
    output logic [DROP_W-1:0] drop_count,
    output logic [IDX_W-1:0]  cur_index,
    output logic              rx_active
);
    logic [15:0]      a_status, h_status, wb_status;
    logic [31:0]      a_addr, h_addr;
    logic [LEN_W-1:0] h_len, byte_cnt;
    logic             b_empty, wb_we, cnt_clr, cnt_inc, room, len_bad, evt_q;
    logic [IDX_W-1:0] ptr, nxt_ptr;
    logic             evt_clr;

    assign evt_clr = host_we && host_sel == 2'd3 && host_wdata[rxr_pkg::EVT_BIT];

    rxr_desc_ram #(.NUM_DESC(NUM_DESC), .LEN_W(LEN_W)) u_ram (
        .clk(clk), .rst_n(rst_n),
        .host_we(host_we), .host_sel(host_sel), .host_idx(host_idx),
        .host_wdata(host_wdata),
        .eng_we(wb_we), .eng_idx(ptr), .eng_status(wb_status), .eng_len(byte_cnt),
        .a_idx(ptr), .b_idx(nxt_ptr),
        .a_status(a_status), .a_addr(a_addr), .b_empty(b_empty),
        .h_status(h_status), .h_len(h_len), .h_addr(h_addr)
    );

    rxr_len_track #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN), .MIN_LEN(MIN_LEN)) u_len (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc),
        .cnt(byte_cnt), .room(room), .len_bad(len_bad)
    );

    rxr_engine #(.NUM_DESC(NUM_DESC), .LEN_W(LEN_W), .DROP_W(DROP_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .restart(restart), .kick(kick),
        .rx_valid(rx_valid), .rx_end(rx_end),
        .rx_flags({rx_crc_bad, rx_align_bad, rx_fifo_ovr, rx_late_col}),
        .cur_status(a_status), .cur_addr(a_addr), .nxt_empty(b_empty),
        .byte_cnt(byte_cnt), .room(room), .len_bad(len_bad), .evt_clr(evt_clr),
        .cnt_clr(cnt_clr), .cnt_inc(cnt_inc), .wb_we(wb_we), .wb_status(wb_status),
        .buf_we(buf_we), .buf_addr(buf_addr), .ptr(ptr), .nxt_ptr(nxt_ptr),
        .evt_q(evt_q), .drop_cnt(drop_count), .active(rx_active)
    );

    always_comb begin
        unique case (host_sel)
            2'd0:    host_rdata = {16'h0, h_status};
            2'd1:    host_rdata = {{(32-LEN_W){1'b0}}, h_len};
            2'd2:    host_rdata = h_addr;
            default: host_rdata = {6'h0, evt_q, 25'h0};
        endcase
    end

    assign buf_byte  = rx_data;
    assign frame_evt = evt_q;
    assign cur_index = ptr;
endmodule

// File: tb/rx_desc_ring_bench.sv
module rx_desc_ring_bench;
    logic        clk = 1'b0;
    logic        rst_n, restart, kick, host_we;
    logic [1:0]  host_sel;
    logic [2:0]  host_idx;
    logic [31:0] host_wdata, host_rdata;
    logic        rx_valid, rx_end, rx_crc_bad, rx_align_bad, rx_fifo_ovr, rx_late_col;
    logic [7:0]  rx_data, buf_byte;
    logic        buf_we, frame_evt, rx_active;
    logic [31:0] buf_addr;
    logic [15:0] drop_count;
    logic [2:0]  cur_index;
    int nchk = 0;
    int nfail = 0;
    int we_seen;
    int bad_beats;
    logic [31:0] rd;

    always #4 clk = ~clk;

    rx_desc_ring u_rx_desc_ring (
        .clk(clk), .rst_n(rst_n), .restart(restart), .kick(kick),
        .host_we(host_we), .host_sel(host_sel), .host_idx(host_idx),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_end(rx_end),
        .rx_crc_bad(rx_crc_bad), .rx_align_bad(rx_align_bad),
        .rx_fifo_ovr(rx_fifo_ovr), .rx_late_col(rx_late_col),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_byte(buf_byte),
        .frame_evt(frame_evt), .drop_count(drop_count),
        .cur_index(cur_index), .rx_active(rx_active)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hwr(input logic [1:0] s, input logic [2:0] i, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_sel = s; host_idx = i; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic hrd(input logic [1:0] s, input logic [2:0] i, output logic [31:0] d);
        @(negedge clk);
        host_sel = s; host_idx = i;
        #1 d = host_rdata;
    endtask

    task automatic pulse_kick();
        @(negedge clk); kick = 1'b1;
        @(negedge clk); kick = 1'b0;
    endtask

    // own=1: bytes must land at base+offset for the first 1520 bytes (R6, R4)
    task automatic send(input int n, input logic [31:0] base, input logic [3:0] fl,
                        input logic [7:0] seed, input bit own);
        we_seen = 0; bad_beats = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = 8'(i) ^ seed; rx_end = (i == n - 1);
            {rx_crc_bad, rx_align_bad, rx_fifo_ovr, rx_late_col} = (i == n - 1) ? fl : 4'h0;
            #1;
            if (buf_we) we_seen++;
            if (own && i < 1520) begin
                if (!buf_we || buf_addr !== base + 32'(i) || buf_byte !== rx_data) bad_beats++;
            end else if (buf_we) bad_beats++;
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_end = 1'b0;
        {rx_crc_bad, rx_align_bad, rx_fifo_ovr, rx_late_col} = 4'h0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R10 active after reset", 32'(rx_active), 0);
        check("R10 pointer after reset", 32'(cur_index), 0);
        check("R10 drop count after reset", 32'(drop_count), 0);
        hrd(2'd0, 3'd0, rd); check("R10 descriptor zeroed", rd, 0);
        check("R9 event clear after reset", 32'(frame_evt), 0);
    endtask

    task automatic t_basic();
        hwr(2'd2, 3'd0, 32'h1000);
        hwr(2'd0, 3'd0, 32'h8000);
        pulse_kick();
        check("R8 kick resumes on owned", 32'(rx_active), 1);
        send(100, 32'h1000, 4'h0, 8'h5A, 1'b1);
        check("R6 byte writes", 32'(bad_beats), 0);
        check("R6 write count", 32'(we_seen), 100);
        hrd(2'd0, 3'd0, rd); check("R1 R3 status handed back", rd, 32'h0800);
        hrd(2'd1, 3'd0, rd); check("R3 length", rd, 100);
        check("R9 event set", 32'(frame_evt), 1);
        hrd(2'd3, 3'd0, rd); check("R11 event read", rd, 32'h0200_0000);
        check("R2 pointer advanced", 32'(cur_index), 1);
        check("R7 stalls on unowned", 32'(rx_active), 0);
    endtask

    task automatic t_evt_clear();
        hwr(2'd3, 3'd0, 32'h0);
        check("R9 zero write keeps event", 32'(frame_evt), 1);
        hwr(2'd3, 3'd0, 32'h0200_0000);
        check("R9 one write clears event", 32'(frame_evt), 0);
    endtask

    task automatic t_stall();
        send(80, 32'h0, 4'h0, 8'h11, 1'b0);
        check("R7 no buffer writes when dropping", 32'(bad_beats), 0);
        check("R7 drop counted", 32'(drop_count), 1);
        check("R7 pointer held", 32'(cur_index), 1);
        hrd(2'd0, 3'd1, rd); check("R1 unowned descriptor untouched", rd, 0);
        pulse_kick();
        check("R8 kick on unowned stays stalled", 32'(rx_active), 0);
    endtask

    task automatic t_errors_long();
        hwr(2'd2, 3'd1, 32'h2000);
        hwr(2'd0, 3'd1, 32'hA000);
        hwr(2'd2, 3'd0, 32'h3000);
        hwr(2'd0, 3'd0, 32'h8004);
        pulse_kick();
        check("R8 resumes after return", 32'(rx_active), 1);
        send(40, 32'h2000, 4'b1100, 8'h33, 1'b1);
        check("R6 short frame writes", 32'(bad_beats), 0);
        hrd(2'd0, 3'd1, rd); check("R4 R5 short frame status", rd, 32'h2834);
        hrd(2'd1, 3'd1, rd); check("R3 short length", rd, 40);
        check("R2 wrap to base", 32'(cur_index), 0);
        check("R2 continues when next owned", 32'(rx_active), 1);
        send(1530, 32'h3000, 4'b0011, 8'hC3, 1'b1);
        check("R4 bytes past limit not written", 32'(bad_beats), 0);
        check("R4 write count capped", 32'(we_seen), 1520);
        hrd(2'd0, 3'd0, rd); check("R5 long status keeps preset", rd, 32'h0827);
        hrd(2'd1, 3'd0, rd); check("R3 long length", rd, 1530);
        check("R7 stall after long", 32'(rx_active), 0);
    endtask

    task automatic t_bounds();
        hwr(2'd0, 3'd1, 32'hA000);
        pulse_kick();
        send(64, 32'h2000, 4'h0, 8'h07, 1'b1);
        hrd(2'd0, 3'd1, rd); check("R4 64 bytes no error", rd, 32'h2800);
        check("R2 wrap again", 32'(cur_index), 0);
        hwr(2'd0, 3'd0, 32'h8000);
        pulse_kick();
        send(1520, 32'h3000, 4'h0, 8'h99, 1'b1);
        check("R4 1520 write count", 32'(we_seen), 1520);
        hrd(2'd0, 3'd0, rd); check("R4 1520 bytes no error", rd, 32'h0800);
    endtask

    task automatic t_kick_restart();
        hwr(2'd0, 3'd1, 32'h8000);
        pulse_kick();
        check("R8 resume at index 1", 32'(cur_index), 1);
        pulse_kick();
        check("R8 kick while active no effect", 32'(cur_index), 1);
        check("R8 still active", 32'(rx_active), 1);
        send(70, 32'h2000, 4'h0, 8'h42, 1'b1);
        check("R2 no wrap steps by one", 32'(cur_index), 2);
        hwr(2'd0, 3'd2, 32'h8000);
        pulse_kick();
        check("R8 active at index 2", 32'(rx_active), 1);
        @(negedge clk); restart = 1'b1;
        @(negedge clk); restart = 1'b0;
        check("R10 restart pointer home", 32'(cur_index), 0);
        check("R10 restart inactive", 32'(rx_active), 0);
    endtask

    initial begin
        #(8 * 150000);
        nfail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; restart = 1'b0; kick = 1'b0; host_we = 1'b0;
        host_sel = 2'd0; host_idx = 3'd0; host_wdata = 32'h0;
        rx_valid = 1'b0; rx_end = 1'b0; rx_data = 8'h0;
        rx_crc_bad = 1'b0; rx_align_bad = 1'b0; rx_fifo_ovr = 1'b0; rx_late_col = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_evt_clear();
        t_stall();
        t_errors_long();
        t_bounds();
        t_kick_restart();
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule